// File: doc/BRIEF.md
# One-Way Protection Configuration Register

This register keeps the protection settings that an access guard consults on every program-memory and data-EEPROM access. It holds three settings for each of `NREG` program regions: code protection, write protection and a table-read restriction. It also holds two data-EEPROM settings and one bit that locks the configuration itself. Every bit is active-low: 1 means unprotected and 0 means protected. The whole word drives the guard in parallel.

Writes arrive on a table-write style port. Each write is tagged as coming either from internal execution or from the external programmer. A write can only move bits from 1 to 0. Bits return to 1 only through an erase command. The register accepts an erase only when it comes from the external programmer path. An erase clears either the whole word or the three settings of one region.

Any request that the register refuses leaves the stored word as it was and sets a sticky rejection flag. Only reset clears that flag. Reset models a blank device: every protection bit comes up at 1.

Top module: `prot_cfg_reg`

## Requirements
- R1: Reset sets every bit of `prot_o` to 1 and clears `rej_o`. Bit layout of `prot_o`, with N = `NREG`:
  - bits [N-1:0]: code protect for regions 0 to N-1;
  - bits [2N-1:N]: write protect;
  - bits [3N-1:2N]: table-read restriction;
  - bit 3N: EEPROM code protect;
  - bit 3N+1: EEPROM write protect;
  - bit 3N+2: configuration lock.
- R2: An accepted write makes `prot_o` equal to the old value AND `wr_data`, one clock after the request. A 1 written to a bit that is already 0 leaves that bit at 0.
- R3: An erase with `er_ext`=0 has no effect on `prot_o` and sets `rej_o`.
- R4: An erase with `er_ext`=1 and `er_chip`=1 sets all bits of `prot_o` to 1, the configuration lock included, one clock after the request.
- R5: A block erase (`er_ext`=1, `er_chip`=0) sets to 1 only the three bits of region `er_region` (bits r, N+r and 2N+r). A region index of N or above changes nothing and sets `rej_o`.
- R6: An internal write (`wr_ext`=0) while the configuration lock bit is 0 is ignored entirely and sets `rej_o`.
- R7: An internal write never changes the configuration lock bit; the value of that bit in `wr_data` is disregarded. An external write may clear the lock bit and is not blocked by it.
- R8: When an accepted erase and a write arrive in the same cycle, the erase is applied, the write is dropped and `rej_o` is set.
- R9: Once set, `rej_o` stays at 1 until reset, whatever requests follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write request |
| wr_ext | input | 1 | 1: write comes from the external programmer; 0: from internal execution |
| wr_data | input | 3*NREG+3 | Write data; a 0 clears the bit, a 1 leaves it as it is |
| er_en | input | 1 | Erase request |
| er_ext | input | 1 | 1: erase comes from the external programmer |
| er_chip | input | 1 | 1: full erase; 0: block erase of `er_region` |
| er_region | input | clog2(NREG) | Region index for a block erase |
| prot_o | output | 3*NREG+3 | All protection bits, to the access guard |
| rej_o | output | 1 | Sticky flag: a request was refused |

## Verification
The hardest situation to reach is a block erase with every bit already at 0. Only that starting point shows that the erase restores exactly three bits and touches nothing else. The stimulus reaches it from reset in two steps. First an external write of all zeros clears the whole word, lock included. Then the block erase runs for every region code, including the codes that do not name a region. Before each pass the bench resets the design, so the sticky flag is clear again and the refusal of each out-of-range code shows up on its own.

// File: rtl/prot_cfg_reg.sv
module prot_cfg_reg #(
  parameter int NREG = 5,
  localparam int RW = (NREG < 2) ? 1 : $clog2(NREG),
  localparam int W  = 3 * NREG + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_ext,
  input  logic [W-1:0]  wr_data,
  input  logic          er_en,
  input  logic          er_ext,
  input  logic          er_chip,
  input  logic [RW-1:0] er_region,
  output logic [W-1:0]  prot_o,
  output logic          rej_o
);
  localparam int LOCK_B = 3 * NREG + 2;

  logic [W-1:0] q, d, blk_mask, wmask;
  logic         rej_q;

  wire region_ok = {1'b0, er_region} < (RW+1)'(NREG);
  wire erase_ok  = er_en & er_ext & (er_chip | region_ok);
  wire wr_ok     = wr_en & ~erase_ok & (wr_ext | q[LOCK_B]);
  wire wr_bad    = wr_en & (erase_ok | (~wr_ext & ~q[LOCK_B]));
  wire er_bad    = er_en & ~erase_ok;

  for (genvar g = 0; g < NREG; g++) begin : g_blk
    assign blk_mask[g]          = (er_region == RW'(g));
    assign blk_mask[NREG + g]   = (er_region == RW'(g));
    assign blk_mask[2*NREG + g] = (er_region == RW'(g));
  end
  assign blk_mask[W-1:3*NREG] = '0;

  assign wmask = wr_ext ? wr_data : (wr_data | (W'(1) << LOCK_B));

  always_comb begin
    d = q;
    if (erase_ok) d = er_chip ? '1 : (q | blk_mask);
    else if (wr_ok) d = q & wmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '1;
      rej_q <= 1'b0;
    end else begin
      q     <= d;
      rej_q <= rej_q | wr_bad | er_bad;
    end
  end

  assign prot_o = q;
  assign rej_o  = rej_q;
endmodule

// File: rtl/prot_cfg_reg_chk.sv
module prot_cfg_reg_chk #(
  parameter int NREG = 5,
  localparam int W = 3 * NREG + 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         wr_ext,
  input logic         er_en,
  input logic         er_ext,
  input logic         er_chip,
  input logic [W-1:0] prot_o,
  input logic         rej_o
);
  localparam int LOCK_B = 3 * NREG + 2;

  AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !(er_en && er_ext) |=> ((prot_o & ~$past(prot_o)) == '0)); // R2

  AST_INT_ERASE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (er_en && !er_ext && !wr_en) |=> $stable(prot_o)); // R3

  AST_CHIP_ERASE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (er_en && er_ext && er_chip) |=> (&prot_o)); // R4

  AST_BLOCK_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (er_en && er_ext && !er_chip) |=> (prot_o[W-1:3*NREG] == $past(prot_o[W-1:3*NREG]))); // R5

  AST_LOCKED_INT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ext && !prot_o[LOCK_B] && !er_en) |=> ($stable(prot_o) && rej_o)); // R6

  AST_INT_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ext && !er_en) |=> (prot_o[LOCK_B] == $past(prot_o[LOCK_B]))); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rej_o |=> rej_o); // R9
endmodule

bind prot_cfg_reg prot_cfg_reg_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ext(wr_ext),
  .er_en(er_en), .er_ext(er_ext), .er_chip(er_chip),
  .prot_o(prot_o), .rej_o(rej_o)
);

// File: tb/tb_prot_cfg_reg.sv
module tb_prot_cfg_reg;
  localparam int N  = 5;
  localparam int RW = 3;
  localparam int W  = 3 * N + 3;
  localparam int LK = 3 * N + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_ext = 0, er_en = 0, er_ext = 0, er_chip = 0;
  logic [W-1:0] wr_data = '0;
  logic [RW-1:0] er_region = '0;
  logic [W-1:0] prot_o;
  logic rej_o;

  logic [W-1:0] exp_p;
  logic exp_r;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  prot_cfg_reg #(.NREG(N)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ext(wr_ext), .wr_data(wr_data),
    .er_en(er_en), .er_ext(er_ext), .er_chip(er_chip), .er_region(er_region),
    .prot_o(prot_o), .rej_o(rej_o)
  );

  task automatic check(input string tag);
    checks++;
    if (prot_o !== exp_p || rej_o !== exp_r) begin
      errors++;
      $display("FAIL %s: prot=%h rej=%b expected prot=%h rej=%b", tag, prot_o, rej_o, exp_p, exp_r);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    exp_p = '1; exp_r = 1'b0;
  endtask

  task automatic op(input logic we, input logic wx, input logic [W-1:0] wd,
                    input logic ee, input logic ex, input logic ec, input int rg);
    logic acc_er;
    @(negedge clk);
    wr_en = we; wr_ext = wx; wr_data = wd;
    er_en = ee; er_ext = ex; er_chip = ec; er_region = RW'(rg);
    @(negedge clk);
    wr_en = 0; er_en = 0;
    acc_er = ee && ex && (ec || rg < N);
    if (ee && !acc_er) exp_r = 1'b1;
    if (acc_er) begin
      if (ec) exp_p = '1;
      else begin
        exp_p[rg] = 1'b1; exp_p[N+rg] = 1'b1; exp_p[2*N+rg] = 1'b1;
      end
      if (we) exp_r = 1'b1;
    end else if (we) begin
      if (!wx && !exp_p[LK]) exp_r = 1'b1;
      else if (wx) exp_p = exp_p & wd;
      else for (int b = 0; b < W; b++) if (b != LK && !wd[b]) exp_p[b] = 1'b0;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] lfsr;
    do_reset();
    check("R1 reset state");

    for (int i = 0; i < W; i++) begin
      op(0, 0, '0, 1, 1, 1, 0);            check("R4 chip erase");
      op(1, 1, ~(W'(1) << i), 0, 0, 0, 0); check("R2 clear single bit");
      op(1, 1, '1, 0, 0, 0, 0);            check("R2 write one on zero");
    end

    for (int r = 0; r < 8; r++) begin
      do_reset();
      op(1, 1, '0, 0, 0, 0, 0); check("R2 clear all external");
      op(0, 0, '0, 1, 1, 0, r); check(r < N ? "R5 block erase" : "R5 region out of range");
    end

    do_reset();
    lfsr = 18'h2B5C1;
    for (int k = 0; k < 40; k++) begin
      lfsr = {lfsr[W-2:0], lfsr[17] ^ lfsr[10]};
      op(1, 0, lfsr | (W'(1) << k % W), 0, 0, 0, 0);
      check("R7 internal write keeps lock, R2 AND");
      if (k % 8 == 7) begin op(0, 0, '0, 1, 1, 1, 0); check("R4 refill"); end
    end

    do_reset();
    op(1, 1, ~(W'(1) << 3), 0, 0, 0, 0); check("R2 setup");
    op(0, 0, '0, 1, 0, 1, 0);            check("R3 internal chip erase ignored");
    do_reset();
    op(1, 1, '0, 0, 0, 0, 0);            check("R2 setup");
    op(0, 0, '0, 1, 0, 0, 2);            check("R3 internal block erase ignored");

    do_reset();
    op(1, 1, ~(W'(1) << LK), 0, 0, 0, 0); check("R7 external clears lock");
    op(1, 0, '0, 0, 0, 0, 0);             check("R6 locked internal write ignored");
    op(1, 1, 18'h0F0F0, 0, 0, 0, 0);      check("R7 external write while locked");

    do_reset();
    op(1, 1, 18'h15A5A, 0, 0, 0, 0);      check("R2 setup");
    op(1, 1, '0, 1, 1, 1, 0);             check("R8 erase beats write");
    op(1, 1, 18'h3F0FF, 0, 0, 0, 0);      check("R9 flag held after write");
    op(0, 0, '0, 1, 1, 0, 1);             check("R9 flag held after erase");
    do_reset();
    check("R1 reset clears flag");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule